// File: doc/BRIEF.md
# Set-Associative Data Cache Miss Controller with Write-Back Buffer

This block is the control and storage core of a small 4-way set-associative data cache. CPU reads and writes arrive as held requests carrying a 32-bit address and a full longword of write data. The block answers hits from its own line storage. On a miss it runs four-beat line refills over a simple request/acknowledge memory bus. A mode input picks how writes behave. In copy-back mode, a write miss allocates the line and marks it modified. In store-through mode, a write goes to memory and a write miss leaves the cache untouched.

When the least recently used line chosen for replacement is modified, it is moved into a single-line holding buffer together with its line address. The refill of the new line then goes first. The held line is written out afterwards, and hits keep being served while that happens. An access that needs the bus and touches the held line is stalled until the write-out ends. So is an access that would need the buffer while it is still full.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid and the holding buffer is empty. `cpu_ready` and `mem_req` are low, and the first access to any address fetches its line from memory.
- R2: A read miss fetches the line as four read beats at byte offsets 0, 4, 8 and 12 in ascending order, then returns the addressed longword. A later read of the same line completes with no bus activity and no wait.
- R3: In copy-back mode a write miss refills the line and merges the write data into it. The line is marked modified, and the merged data reaches memory when the line is later replaced. A line is never modified without being valid.
- R4: The victim is an invalid way if one exists, and otherwise the least recently used way of the set. Hits and refills make the touched way the most recently used.
- R5: When a modified victim is replaced, all four read beats of the refill come before any write beat of the victim.
- R6: The four write beats of a held line go out in ascending order at offsets 0 to 12, to the victim's line address with address bits 31 to 29 forced to 0.
- R7: While the held line is being written out, hits complete with no wait.
- R8: In store-through mode a write miss performs exactly one memory write of the data and allocates nothing. A following read of that address misses and returns the written data.
- R9: In store-through mode a write hit updates both the cache and memory and leaves the line unmodified, so its later replacement produces no write beats.
- R10: A miss whose victim is modified while the buffer is still occupied waits until the buffer is empty. The buffer contents and address stay unchanged until their last write beat is acknowledged.
- R11: An access needing the bus whose line matches the held line waits until that line has been written out. A refill of it then returns the up-to-date data.
- R12: Once `mem_req` is raised, it and `mem_addr` and `mem_we` stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1: copy-back writes, 0: store-through writes |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | 32 | Byte address (longword aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1: write beat, 0: read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted / read data valid |

## Verification
A sweep reads every longword of sixteen lines against arithmetically computed memory contents. This separates a correct refill order and return path from a beat or offset error. Sequences of lines aimed at one set tell true LRU apart from round-robin or first-way replacement. Back-to-back modified evictions and a re-read of the just-evicted line expose any overwrite of the holding buffer and any stale refill. The bus log shows whether refill beats precede write-out beats and whether the top address bits are cleared. Store-through write hits and misses followed by forced evictions tell a clean line from a wrongly modified one. A memory latency that varies per beat exercises the handshake.

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wb_mode,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int IW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);
  localparam int TW = 28 - IW;

  typedef enum logic [1:0] {IDLE, FILL, WTW} st_t;
  st_t st;

  logic [TW-1:0]        tag_q  [SETS][WAYS];
  logic [31:0]          data_q [SETS][WAYS][4];
  logic [WW-1:0]        age    [SETS][WAYS];
  logic [SETS*WAYS-1:0] vld, drt;

  logic [1:0]    beat, dbeat;
  logic [WW-1:0] fw, hw, vic, tw;
  logic          hit, found, buf_vld, drn;
  logic [27:0]   buf_la;
  logic [31:0]   buf_line [4];

  wire [IW-1:0] idx  = cpu_addr[4 +: IW];
  wire [TW-1:0] tg   = cpu_addr[31 -: TW];
  wire [1:0]    wd   = cpu_addr[3:2];
  wire          idle = (st == IDLE);
  wire          fill_busy = (st == FILL);
  wire          wt_wr = cpu_we && !wb_mode;
  wire          vic_dirty = vld[{idx, vic}] && drt[{idx, vic}];
  wire          buf_hit = buf_vld && (buf_la == cpu_addr[31:4]);
  wire          blk_full = !wt_wr && !hit && vic_dirty && buf_vld;
  wire          go = idle && cpu_req && (wt_wr || !hit) && !drn && !buf_hit && !blk_full;
  wire          drain_go = buf_vld && !drn && idle && !go;
  wire          fill_end = fill_busy && mem_ack && (beat == 2'd3);
  wire          wtw_end = (st == WTW) && mem_ack;
  wire          drain_end = drn && mem_ack && (dbeat == 2'd3);
  wire          touch = (idle && cpu_ready) || fill_end || (wtw_end && hit);
  wire          wr_hit = (idle && cpu_ready && cpu_we) || (wtw_end && hit);

  always_comb begin
    hit = 1'b0;
    hw  = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[{idx, WW'(w)}] && tag_q[idx][w] == tg) begin
        hit = 1'b1;
        hw  = WW'(w);
      end
  end

  always_comb begin
    vic   = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !vld[{idx, WW'(w)}]) begin
        vic   = WW'(w);
        found = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age[idx][w] == WW'(WAYS - 1)) vic = WW'(w);
  end

  assign tw        = fill_busy ? fw : hw;
  assign cpu_ready = (idle && cpu_req && hit && !wt_wr) || wtw_end;
  assign cpu_rdata = data_q[idx][hw][wd];
  assign mem_req   = drn || !idle;
  assign mem_we    = drn || (st == WTW);
  assign mem_addr  = drn ? {3'b000, buf_la[24:0], dbeat, 2'b00} :
                     fill_busy ? {cpu_addr[31:4], beat, 2'b00} : {cpu_addr[31:2], 2'b00};
  assign mem_wdata = drn ? buf_line[dbeat] : cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      beat    <= '0;
      dbeat   <= '0;
      fw      <= '0;
      vld     <= '0;
      drt     <= '0;
      buf_vld <= 1'b0;
      drn     <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age[s][w] <= WW'(w);
    end else begin
      if (touch) begin
        for (int w = 0; w < WAYS; w++)
          if (age[idx][w] < age[idx][tw]) age[idx][w] <= age[idx][w] + 1'b1;
        age[idx][tw] <= '0;
      end
      if (idle && cpu_ready && cpu_we) drt[{idx, hw}] <= 1'b1;
      case (st)
        IDLE: if (go) begin
          if (wt_wr) st <= WTW;
          else begin
            st   <= FILL;
            beat <= '0;
            fw   <= vic;
            vld[{idx, vic}] <= 1'b0;
            drt[{idx, vic}] <= 1'b0;
            if (vic_dirty) buf_vld <= 1'b1;
          end
        end
        FILL: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (beat == 2'd3) begin
            vld[{idx, fw}] <= 1'b1;
            st <= IDLE;
          end
        end
        default: if (mem_ack) st <= IDLE;
      endcase
      if (drain_go) begin
        drn   <= 1'b1;
        dbeat <= '0;
      end else if (drn && mem_ack) begin
        dbeat <= dbeat + 1'b1;
        if (drain_end) begin
          drn     <= 1'b0;
          buf_vld <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && !wt_wr) begin
      tag_q[idx][vic] <= tg;
      if (vic_dirty) begin
        buf_la <= {tag_q[idx][vic], idx};
        for (int b = 0; b < 4; b++) buf_line[b] <= data_q[idx][vic][b];
      end
    end
    if (fill_busy && mem_ack) data_q[idx][fw][beat] <= mem_rdata;
    if (wr_hit) data_q[idx][hw][wd] <= cpu_wdata;
  end
endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
  parameter int NL = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [31:0]   mem_addr,
  input logic          drn,
  input logic          fill_busy,
  input logic          buf_vld,
  input logic [27:0]   buf_la,
  input logic [NL-1:0] vld,
  input logic [NL-1:0] drt
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_DRAIN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drn |-> mem_addr[31:29] == 3'b000 && mem_we); // R6
  AST_FILL_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !drn && !mem_we); // R5
  AST_BUF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    buf_vld && !(drn && mem_ack && mem_addr[3:2] == 2'd3) |=> buf_vld && $stable(buf_la)); // R10
  AST_DIRTY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (drt & ~vld) == '0); // R3
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R2
endmodule

bind dcache_wb dcache_wb_chk #(.NL(SETS * WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .drn(drn), .fill_busy(fill_busy), .buf_vld(buf_vld), .buf_la(buf_la),
  .vld(vld), .drt(drt)
);

// File: tb/dcache_wb_test.sv
module dcache_wb_test;
  logic clk = 1'b0, rst_n = 1'b0, wb_mode = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #4 clk = ~clk;

  dcache_wb uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  logic        log_we   [0:1023];
  logic [31:0] log_addr [0:1023];
  logic [31:0] log_data [0:1023];
  int log_n = 0, wcnt = 0, nbeats = 0;

  function automatic logic [31:0] initv(input int i);
    return (i * 32'h0001_0003) ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= nbeats % 3) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
        if (log_n < 1024) begin
          log_we[log_n] = mem_we;
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_wdata;
          log_n++;
        end
        nbeats++;
      end else wcnt++;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    waits = 0; rd = 'x;
    forever begin
      #1;
      if (cpu_ready) begin
        rd = cpu_rdata;
        break;
      end
      @(negedge clk);
      waits++;
      if (waits > 3000) begin
        chk("access timeout", 32'(waits), 32'd0);
        break;
      end
    end
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  function automatic int nwr(input int from);
    int n = 0;
    for (int k = from; k < log_n; k++) if (log_we[k]) n++;
    return n;
  endfunction

  task automatic run(input string r, input int at, input logic we, input logic [31:0] base);
    logic ok = 1'b1;
    for (int k = 0; k < 4; k++)
      if (at + k >= log_n || log_we[at + k] !== we || log_addr[at + k] !== base + 32'(4 * k)) ok = 1'b0;
    chk(r, {31'd0, ok}, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd, a;
    int w, m;
    for (int i = 0; i < 1024; i++) mem[i] = initv(i);
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", {31'd0, cpu_ready}, 32'd0);
    chk("R1 mem_req at reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 bus idle after reset", {31'd0, mem_req}, 32'd0);

    // R2 sweep: 16 lines across all sets, every longword
    m = log_n;
    for (int i = 0; i < 64; i++) begin
      a = 32'h800 + 32'(4 * i);
      acc(1'b0, a, 0, rd, w);
      chk("R2 sweep data", rd, initv(int'(a[11:2])));
      if (i % 4 != 0) chk("R2 hit no wait", 32'(w), 32'd0);
    end
    chk("R2 sweep beat count", 32'(log_n - m), 32'd64);
    run("R2 beat order", m, 1'b0, 32'h800);
    m = log_n;
    acc(1'b0, 32'h100, 0, rd, w);
    run("R1 first access fetches", m, 1'b0, 32'h100);

    // R4 LRU in set 1
    foreach (rd[i]) ;
    for (int k = 0; k < 4; k++) acc(1'b0, 32'h010 + 32'(k * 64), 0, rd, w);
    acc(1'b0, 32'h010, 0, rd, w);
    chk("R4 touch hit", 32'(w), 32'd0);
    acc(1'b0, 32'h110, 0, rd, w);
    m = log_n;
    acc(1'b0, 32'h010, 0, rd, w);
    acc(1'b0, 32'h0D0, 0, rd, w);
    chk("R4 recent lines kept", 32'(log_n - m), 32'd0);
    acc(1'b0, 32'h050, 0, rd, w);
    chk("R4 LRU line evicted", 32'(log_n - m), 32'd4);
    acc(1'b0, 32'h090, 0, rd, w);
    chk("R4 next LRU evicted", 32'(log_n - m), 32'd8);

    // R3 R5 R7 copy-back in set 2
    wb_mode = 1'b1;
    m = log_n;
    acc(1'b1, 32'h024, 32'hD00D_0024, rd, w);
    chk("R3 write miss refill only", 32'(log_n - m), 32'd4);
    chk("R3 write miss no write beat", 32'(nwr(m)), 32'd0);
    acc(1'b0, 32'h024, 0, rd, w);
    chk("R3 merged data", rd, 32'hD00D_0024);
    acc(1'b0, 32'h028, 0, rd, w);
    chk("R3 rest of line from memory", rd, initv(32'h028 >> 2));
    for (int k = 1; k < 4; k++) acc(1'b0, 32'h020 + 32'(k * 64), 0, rd, w);
    m = log_n;
    acc(1'b0, 32'h120, 0, rd, w);
    chk("R2 refill data", rd, initv(32'h120 >> 2));
    acc(1'b0, 32'h060, 0, rd, w);
    chk("R7 hit during drain no wait", 32'(w), 32'd0);
    chk("R7 drain still pending", {31'd0, nwr(m) < 4}, 32'd1);
    settle();
    run("R5 refill first", m, 1'b0, 32'h120);
    run("R6 drain ascending", m + 4, 1'b1, 32'h020);
    chk("R3 merged data written back", mem[32'h024 >> 2], 32'hD00D_0024);
    chk("R3 clean words written back", mem[32'h020 >> 2], initv(32'h020 >> 2));

    // R6 top address bits in set 3
    acc(1'b1, 32'hE000_0030, 32'hBEEF_0030, rd, w);
    for (int k = 1; k < 4; k++) acc(1'b0, 32'h030 + 32'(k * 64), 0, rd, w);
    m = log_n;
    acc(1'b0, 32'h130, 0, rd, w);
    settle();
    run("R6 drain address top bits zero", m + 4, 1'b1, 32'h0000_0030);
    chk("R6 drain data", log_data[m + 4], 32'hBEEF_0030);

    // R10 two modified evictions in set 0
    for (int k = 0; k < 4; k++) acc(1'b1, 32'(k * 64), 32'hA000_0000 + 32'(k * 64), rd, w);
    settle();
    m = log_n;
    chk("R3 write misses evict clean only", 32'(nwr(m - 16)), 32'd0);
    acc(1'b0, 32'h200, 0, rd, w);
    acc(1'b0, 32'h240, 0, rd, w);
    chk("R10 second refill data", rd, initv(32'h240 >> 2));
    settle();
    run("R10 refill A", m, 1'b0, 32'h200);
    run("R10 first victim drained", m + 4, 1'b1, 32'h000);
    run("R10 refill B after drain", m + 8, 1'b0, 32'h240);
    run("R10 second victim drained", m + 12, 1'b1, 32'h040);
    chk("R10 first victim data", mem[0], 32'hA000_0000);
    chk("R10 second victim data", mem[16], 32'hA000_0040);

    // R11 re-read of the held line
    m = log_n;
    acc(1'b0, 32'h280, 0, rd, w);
    acc(1'b0, 32'h080, 0, rd, w);
    chk("R11 up-to-date data", rd, 32'hA000_0080);
    settle();
    run("R11 refill new line", m, 1'b0, 32'h280);
    run("R11 held line written first", m + 4, 1'b1, 32'h080);
    run("R11 refill after drain", m + 8, 1'b0, 32'h080);
    run("R11 next victim drained", m + 12, 1'b1, 32'h0C0);

    // R8 R9 store-through in set 0
    wb_mode = 1'b0;
    m = log_n;
    acc(1'b1, 32'h300, 32'h7777_0300, rd, w);
    chk("R8 one write beat", 32'(log_n - m), 32'd1);
    chk("R8 write beat data", log_data[m], 32'h7777_0300);
    chk("R8 write beat addr", log_addr[m], 32'h300);
    m = log_n;
    acc(1'b0, 32'h300, 0, rd, w);
    chk("R8 no allocation, read misses", 32'(log_n - m), 32'd4);
    chk("R8 read returns written data", rd, 32'h7777_0300);
    m = log_n;
    acc(1'b1, 32'h304, 32'h9999_0304, rd, w);
    chk("R9 write hit one beat", 32'(log_n - m), 32'd1);
    acc(1'b0, 32'h304, 0, rd, w);
    chk("R9 cache updated", rd, 32'h9999_0304);
    chk("R9 hit no wait", 32'(w), 32'd0);
    m = log_n;
    for (int k = 1; k < 5; k++) acc(1'b0, 32'h300 + 32'(k * 64), 0, rd, w);
    settle();
    chk("R9 clean eviction no writes", 32'(nwr(m)), 32'd0);
    m = log_n;
    acc(1'b0, 32'h304, 0, rd, w);
    chk("R9 line was evicted", 32'(log_n - m), 32'd4);
    chk("R9 memory updated", rd, 32'h9999_0304);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule